// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

The splitter sits between a core's load/store port and a 32-bit bus master. It takes one operand request: a byte address, a size code, a read/write flag and right-justified write data. It turns that request into the shortest series of naturally aligned bus cycles. Each cycle carries its own byte address, size code and byte-lane enables. The splitter waits for the slave's acknowledge on every cycle. For a read, it joins the returned bytes into one right-justified value.

The request side is a valid/ready handshake. `req_ready` is high only while the splitter is idle. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. The core can hold `req_valid` high for as long as it likes, which gives back-pressure at no cost. The bus and completion pins are plain level signals. `done` is a single-cycle pulse, and `rdata` is valid with it when the operation was a read.

Size codes give the number of bytes as a power of two: 0 is one byte, 1 is two bytes and 2 is four bytes. Byte lane k, at address offset k inside a long word, is carried on data bits [8*(3-k)+7 : 8*(3-k)] and is enabled by `bus_be[3-k]`.

Top module: `misalign_splitter`

## Requirements
- R1: A one-byte request makes exactly one bus cycle of size code 0 at the request address, whatever its offset.
- R2: A two-byte request makes one size-1 cycle at offsets 0 and 2. At offsets 1 and 3 it makes two size-0 cycles, at the address and then at the address plus one.
- R3: A four-byte request makes one size-2 cycle at offset 0. At offset 2 it makes two size-1 cycles, at the address and then at the address plus two. At offsets 1 and 3 it makes three cycles: a byte at the address, then a two-byte cycle at the address plus one, then a byte at the address plus three.
- R4: Every bus cycle is naturally aligned, so the address's low bits are a multiple of the cycle's byte count. `bus_be` enables exactly the lanes the cycle covers, using the lane mapping given above.
- R5: While `bus_req` is high and `bus_ack` is low, the address, size, enables and write data stay unchanged. The next piece is presented only after an acknowledge is sampled.
- R6: A read result is right-justified. The byte from the lowest address is the most significant byte, and any bits above the operand are zero.
- R7: In a write cycle, the operand byte that belongs at address A is driven on the lane for offset A mod 4. The operand's most significant byte belongs at the request address.
- R8: `req_ready` is high exactly when the splitter is idle. `busy` and `bus_req` rise on the edge that accepts a request.
- R9: `done` is high for one cycle, in the cycle after the edge that sampled the final acknowledge. `busy` is low in that cycle, and `rdata` holds the read result.
- R10: An acknowledge that arrives while idle has no effect: no `done`, no `bus_req`.
- R11: A new request can be accepted in the same cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, request may transfer |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Size code: 0 byte, 1 two bytes, 2 four bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Right-justified write operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Right-justified read result |
| bus_req | output | 1 | Bus cycle requested |
| bus_addr | output | ADDR_W | Byte address of the current piece |
| bus_size | output | 2 | Size code of the current piece |
| bus_we | output | 1 | Current cycle writes |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | DATA_W | Lane-steered write data |
| bus_rdata | input | DATA_W | Read data from the slave |
| bus_ack | input | 1 | Transfer acknowledge |

## Verification
A completion pulse and the acceptance of the next request can fall in the same cycle. In that cycle `done` is high and `req_ready` has already returned high. The bench often issues requests back to back: it presents the next request in the very cycle where it checks `done`. It then judges that the new request's first piece appears one edge later, with the correct address and lanes, and that `done` has dropped. Random acknowledge delays, and random data on the lanes that are not enabled, make sure the merge takes only the enabled bytes and advances only on an acknowledge.

// File: rtl/msplit_pkg.sv
package msplit_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} msplit_st_e;
endpackage

// File: rtl/msplit_piece.sv
// Chooses the next aligned piece: the largest power-of-two size that is
// both aligned at the current offset and no larger than the bytes left.
module msplit_piece #(
  parameter int LANES = 4,
  parameter int OFF_W = 2,
  parameter int SZ_W  = 2
) (
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W:0]   remain,
  output logic [SZ_W-1:0]  sz_code,
  output logic [OFF_W:0]   nbytes,
  output logic [LANES-1:0] be
);
  always_comb begin
    logic found;
    found   = 1'b0;
    sz_code = '0;
    nbytes  = (OFF_W+1)'(1);
    for (int s = OFF_W; s >= 0; s--) begin
      if (!found && (int'(remain) >= (1 << s)) && ((int'(off) % (1 << s)) == 0)) begin
        found   = 1'b1;
        sz_code = SZ_W'(s);
        nbytes  = (OFF_W+1)'(1 << s);
      end
    end
  end

  always_comb begin
    for (int o = 0; o < LANES; o++) begin
      be[LANES-1-o] = (o >= int'(off)) && (o < int'(off) + int'(nbytes));
    end
  end
endmodule

// File: rtl/msplit_lanes.sv
// Steers write bytes onto lanes and pulls the enabled read bytes down
// into a right-justified piece value.
module msplit_lanes #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int OFF_W  = 2
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [OFF_W:0]    nbytes,
  input  logic [DATA_W-1:0] wsh,
  input  logic [DATA_W-1:0] rd,
  output logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] piece
);
  logic [DATA_W-1:0] mask;

  generate
    for (genvar b = 0; b < LANES; b++) begin : g_mask
      assign mask[8*b +: 8] = (b < int'(nbytes)) ? 8'hFF : 8'h00;
    end
  endgenerate

  assign wd    = wsh >> (8 * int'(off));
  assign piece = (rd >> (8 * (LANES - int'(off) - int'(nbytes)))) & mask;
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import msplit_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int SZ_W   = $clog2(OFF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [SZ_W-1:0]   bus_size,
  output logic              bus_we,
  output logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  msplit_st_e        st_q;
  logic [ADDR_W-1:0] cur_q;
  logic [OFF_W:0]    left_q;
  logic [DATA_W-1:0] wsh_q, acc_q, rdata_q;
  logic              we_q, done_q;

  logic [OFF_W:0]    pc_n;
  logic [DATA_W-1:0] piece, merged;
  logic [OFF_W:0]    req_n;
  logic              accept, last;

  msplit_piece #(.LANES(LANES), .OFF_W(OFF_W), .SZ_W(SZ_W)) u_piece (
    .off(cur_q[OFF_W-1:0]), .remain(left_q),
    .sz_code(bus_size), .nbytes(pc_n), .be(bus_be)
  );

  msplit_lanes #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_lanes (
    .off(cur_q[OFF_W-1:0]), .nbytes(pc_n), .wsh(wsh_q), .rd(bus_rdata),
    .wd(bus_wdata), .piece(piece)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q == ST_RUN);
  assign bus_req   = busy;
  assign bus_addr  = cur_q;
  assign bus_we    = we_q;
  assign done      = done_q;
  assign rdata     = rdata_q;

  assign accept = req_valid && req_ready;
  assign last   = (left_q == pc_n);
  assign merged = (acc_q << (8 * int'(pc_n))) | piece;
  assign req_n  = (int'(req_size) > OFF_W) ? (OFF_W+1)'(LANES)
                                            : (OFF_W+1)'(1 << req_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
      wsh_q   <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q   <= ST_RUN;
        cur_q  <= req_addr;
        left_q <= req_n;
        we_q   <= req_write;
        acc_q  <= '0;
        wsh_q  <= req_wdata << (8 * (LANES - int'(req_n)));
      end else if (busy && bus_ack) begin
        cur_q  <= cur_q + ADDR_W'(pc_n);
        left_q <= left_q - pc_n;
        acc_q  <= merged;
        wsh_q  <= wsh_q << (8 * int'(pc_n));
        if (last) begin
          st_q    <= ST_IDLE;
          done_q  <= 1'b1;
          rdata_q <= merged;
        end
      end
    end
  end

  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ((int'(bus_addr[OFF_W-1:0]) % (1 << bus_size)) == 0));

  a_r4_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ($countones(bus_be) == (1 << bus_size)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)
                               && $stable(bus_wdata)));

  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && bus_req && !req_ready));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && req_ready));

  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> (!done && !bus_req));
endmodule

// File: tb/misalign_splitter_test.sv
module misalign_splitter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        busy, done, bus_req, bus_we, bus_ack;
  logic [31:0] rdata, bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic [3:0]  bus_be;
  int checks = 0, fails = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  misalign_splitter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd29;
    return t[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int pcount(int sz, int off);
    if (sz == 0) return 1;
    if (sz == 1) return (off % 2 == 1) ? 2 : 1;
    if (off == 0) return 1;
    if (off == 2) return 2;
    return 3;
  endfunction

  function automatic int plen(int sz, int off, int i);
    if (sz == 0) return 1;
    if (sz == 1) return (off % 2 == 1) ? 1 : 2;
    if (off == 0) return 4;
    if (off == 2) return 2;
    return (i == 1) ? 2 : 1;
  endfunction

  function automatic string cnt_tag(int sz);
    if (sz == 0) return "R1";
    if (sz == 1) return "R2";
    return "R3";
  endfunction

  // Called at a falling edge; returns at the falling edge where done is seen.
  task automatic run_op(logic [31:0] a, int sz, bit we, logic [31:0] wd, bit chained);
    int n = 1 << sz;
    logic [31:0] exp_r = '0;
    logic [31:0] pa = a;
    int np = pcount(sz, int'(a[1:0]));
    chk(chained ? "R11 ready at done" : "R8 ready idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_write = we; req_wdata = wd;
    bus_ack = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = $urandom();
    chk("R8 busy after accept", {30'b0, busy, req_ready}, 32'd2);
    chk(chained ? "R11 done dropped" : "R9 done low", {31'b0, done}, 32'd0);
    for (int i = 0; i < np; i++) begin
      int k = plen(sz, int'(a[1:0]), i);
      int off = int'(pa[1:0]);
      logic [3:0] ebe = '0;
      logic [1:0] esz = (k == 1) ? 2'd0 : (k == 2) ? 2'd1 : 2'd2;
      int waits = $urandom_range(0, 2);
      for (int o = 0; o < 4; o++) if (o >= off && o < off + k) ebe[3-o] = 1'b1;
      for (int w = 0; w < waits; w++) begin
        chk("R5 hold addr", bus_addr, pa);
        chk("R5 hold lanes", {27'b0, bus_req, bus_be}, {27'b0, 1'b1, ebe});
        chk("R8 not ready busy", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
      end
      chk({cnt_tag(sz), " piece addr"}, bus_addr, pa);
      chk("R4 piece size", {30'b0, bus_size}, {30'b0, esz});
      chk("R4 piece lanes", {27'b0, bus_req, bus_be}, {27'b0, 1'b1, ebe});
      chk("R7 write flag", {31'b0, bus_we}, {31'b0, we});
      if (we) begin
        for (int o = off; o < off + k; o++) begin
          int j = int'(pa - a) + (o - off);
          chk("R7 lane data", {24'b0, bus_wdata[8*(3-o) +: 8]}, {24'b0, wd[8*(n-1-j) +: 8]});
        end
      end
      for (int o = 0; o < 4; o++)
        bus_rdata[8*(3-o) +: 8] = ebe[3-o] ? mb({pa[31:2], 2'b00} + 32'(o)) : 8'($urandom());
      for (int j = 0; j < k; j++) exp_r = (exp_r << 8) | {24'b0, mb(pa + 32'(j))};
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0; bus_rdata = $urandom();
      if (i < np - 1) chk("R9 no early done", {31'b0, done}, 32'd0);
      pa = pa + 32'(k);
    end
    chk("R9 done pulse", {30'b0, done, busy}, 32'd2);
    chk({cnt_tag(sz), " piece count"}, {31'b0, bus_req}, 32'd0);
    if (!we) chk("R6 read merge", rdata, exp_r);
  endtask

  task automatic idle(int cyc);
    for (int c = 0; c < cyc; c++) begin
      bus_ack = 1'($urandom());
      bus_rdata = $urandom();
      @(negedge clk);
      chk("R10 idle ack ignored", {30'b0, done, bus_req}, 32'd0);
    end
    bus_ack = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5A17_0C3E));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; bus_rdata = '0; bus_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset state", {28'b0, req_ready, busy, bus_req, done}, 32'h8);
    idle(3);
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 4; off++)
        for (int we = 0; we < 2; we++) begin
          logic [31:0] base = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
          run_op(base + 32'(off), sz, we[0], $urandom(), 1'b0);
          idle(1);
        end
    run_op(32'hFFFF_FFFD, 2, 1'b0, '0, 1'b0);
    idle(1);
    begin
      bit ch = 1'b0;
      for (int t = 0; t < 300; t++) begin
        int gap = $urandom_range(0, 2);
        run_op($urandom(), $urandom_range(0, 2), 1'($urandom()), $urandom(), ch);
        if (gap > 0) idle(gap);
        ch = (gap == 0);
      end
    end
    idle(2);
    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule